// File: doc/BRIEF.md
# MSI L1 Line Coherence Controller

This block tracks the coherence state of a small, fully associative set of L1 lines for a directory-based MSI protocol. Each line entry holds a tag, one of three stable states (I, S, M) or one of eight transient states, and a signed count of the invalidation acknowledgements still owed. Three input queues feed it, each with a valid/ready handshake:

- requests from the core: load, store and replacement;
- forwarded requests from the directory side: invalidate, forwarded read, forwarded write and put acknowledgement;
- responses: data from the directory carrying an ack count, data from the previous owner, and invalidation acks.

For each message it accepts, the block may issue one outgoing coherence message and may report one load or store hit to the core. Payloads are reduced to a type, a line address, a requestor ID and an ack count. The data array, the network and the directory are outside the block.

Each cycle at most one message is taken, chosen by fixed priority: responses first, then forwarded requests, then core requests. A message that cannot be handled in its line's current state is held at its queue head by keeping ready low. A held message never blocks a lower-priority queue whose own head can proceed.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every entry is invalid and `msg_valid` and `hit_valid` are low. The first load to any address misses.
- R2: A load (`core_op`=0) to an address with no entry allocates the lowest free entry and issues GetS (`msg_type`=0). A store (`core_op`=1) does the same but issues GetM (`msg_type`=1). While that line waits for data, every core request to it is held with `core_ready` low.
- R3: A line waiting after GetS moves to S on data from the directory (`rsp_type`=0) or from the owner (`rsp_type`=1), and reports a load hit (`hit_store`=0).
- R4: A line waiting for data after GetM completes the store when it receives owner data (whatever count it carries) or directory data whose count brings the ack total to zero. It reports a store hit (`hit_store`=1) and enters M.
- R5: Directory data with a count adds that count to a signed ack counter. Each InvAck (`rsp_type`=2) subtracts one, whether it arrives before or after the data. Once data has arrived, the store completes on the InvAck that brings the counter to zero, and not earlier.
- R6: A load hits in S, in M and in both upgrade states; a store hits in M. A store in S issues GetM and waits in an upgrade state, where stores and replacements are held.
- R7: A replacement (`core_op`=2) in S issues PutS (`msg_type`=2) and one in M issues PutM (`msg_type`=3). While an eviction is outstanding, core requests to the line are held. A put acknowledgement (`fwd_type`=3) frees the entry, so a later load misses again.
- R8: An invalidate (`fwd_type`=0) in S frees the line, in the upgrade-before-data state turns it into a plain write miss, and in the S-eviction state turns it into the invalid-eviction state. Each of these replies with an InvAck (`msg_type`=4) to `fwd_req_id`.
- R9: A forwarded read (`fwd_type`=1) in M or during an M eviction sends data to both requestor and directory (`msg_type`=6) and demotes the line to its shared counterpart. A forwarded write (`fwd_type`=2) sends data to the requestor only (`msg_type`=5) and invalidates the line.
- R10: Forwarded requests to a line waiting for data or acks are held with `fwd_ready` low. The only exception is an invalidate in the upgrade-before-data state.
- R11: At most one of the three readies is high in a cycle, and responses are never held. A held forward does not stop a core request from being taken.
- R12: With all entries in use, a core miss is held. A replacement to an untracked address, and forwards or responses to untracked addresses, are consumed with no output.
- R13: The message or hit caused by an accepted input appears, with that input's address, in the cycle after acceptance and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_valid | input | 1 | Core request present |
| core_ready | output | 1 | Core request taken this cycle |
| core_op | input | 2 | 0 load, 1 store, 2 replacement |
| core_addr | input | ADDR_W | Core request line address |
| fwd_valid | input | 1 | Forwarded request present |
| fwd_ready | output | 1 | Forwarded request taken this cycle |
| fwd_type | input | 2 | 0 invalidate, 1 forwarded read, 2 forwarded write, 3 put ack |
| fwd_addr | input | ADDR_W | Forwarded request line address |
| fwd_req_id | input | ID_W | Requestor to answer |
| rsp_valid | input | 1 | Response present |
| rsp_ready | output | 1 | Response taken this cycle |
| rsp_type | input | 2 | 0 directory data, 1 owner data, 2 InvAck |
| rsp_addr | input | ADDR_W | Response line address |
| rsp_acks | input | ACK_W | Signed ack count carried by directory data |
| msg_valid | output | 1 | Outgoing message strobe |
| msg_type | output | 3 | 0 GetS, 1 GetM, 2 PutS, 3 PutM, 4 InvAck, 5 data to requestor, 6 data to requestor and directory |
| msg_addr | output | ADDR_W | Outgoing message line address |
| msg_id | output | ID_W | Destination requestor, zero for directory-only messages |
| hit_valid | output | 1 | Hit strobe to the core |
| hit_store | output | 1 | 1 store hit, 0 load hit |
| hit_addr | output | ADDR_W | Address of the completed access |

## Verification
A line left in the wrong state surfaces at the ports within one accepted message. A held request may be wrongly taken, or a request that should be taken may be held. The outgoing message or hit on the next cycle may carry the wrong type or be missing. A corrupted ack counter shows up as a store hit one InvAck too early or too late, so the directed sequences count InvAcks on both sides of the data and check for a hit after every one. Priority and hold faults appear as the wrong ready pattern in the very cycle all queues present together.

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl #(
  parameter int LINES  = 4,
  parameter int ADDR_W = 16,
  parameter int ID_W   = 4,
  parameter int ACK_W  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     core_valid,
  output logic                     core_ready,
  input  logic [1:0]               core_op,
  input  logic [ADDR_W-1:0]        core_addr,
  input  logic                     fwd_valid,
  output logic                     fwd_ready,
  input  logic [1:0]               fwd_type,
  input  logic [ADDR_W-1:0]        fwd_addr,
  input  logic [ID_W-1:0]          fwd_req_id,
  input  logic                     rsp_valid,
  output logic                     rsp_ready,
  input  logic [1:0]               rsp_type,
  input  logic [ADDR_W-1:0]        rsp_addr,
  input  logic signed [ACK_W-1:0]  rsp_acks,
  output logic                     msg_valid,
  output logic [2:0]               msg_type,
  output logic [ADDR_W-1:0]        msg_addr,
  output logic [ID_W-1:0]          msg_id,
  output logic                     hit_valid,
  output logic                     hit_store,
  output logic [ADDR_W-1:0]        hit_addr
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

  typedef enum logic [3:0] {
    ST_I, ST_S, ST_M, ST_IS_D, ST_IM_AD, ST_IM_A,
    ST_SM_AD, ST_SM_A, ST_MI_A, ST_SI_A, ST_II_A
  } lst_e;

  localparam logic [1:0] OP_LD = 2'd0, OP_ST = 2'd1, OP_RP = 2'd2;
  localparam logic [1:0] F_INV = 2'd0, F_GETS = 2'd1, F_GETM = 2'd2, F_PACK = 2'd3;
  localparam logic [1:0] R_DIR = 2'd0, R_OWN = 2'd1, R_IACK = 2'd2;
  localparam logic [2:0] M_GETS = 3'd0, M_GETM = 3'd1, M_PUTS = 3'd2, M_PUTM = 3'd3,
                         M_IACK = 3'd4, M_DREQ = 3'd5, M_DBOTH = 3'd6;

  lst_e                     st_q  [LINES];
  logic [ADDR_W-1:0]        tag_q [LINES];
  logic signed [ACK_W-1:0]  ack_q [LINES];

  logic rsp_hit, fwd_hit, core_hit, have_free;
  logic [IDX_W-1:0] rsp_idx, fwd_idx, core_idx, free_idx;

  always_comb begin
    rsp_hit = 1'b0; fwd_hit = 1'b0; core_hit = 1'b0; have_free = 1'b0;
    rsp_idx = '0; fwd_idx = '0; core_idx = '0; free_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (st_q[i] != ST_I && tag_q[i] == rsp_addr)  begin rsp_hit  = 1'b1; rsp_idx  = IDX_W'(i); end
      if (st_q[i] != ST_I && tag_q[i] == fwd_addr)  begin fwd_hit  = 1'b1; fwd_idx  = IDX_W'(i); end
      if (st_q[i] != ST_I && tag_q[i] == core_addr) begin core_hit = 1'b1; core_idx = IDX_W'(i); end
      if (st_q[i] == ST_I) begin have_free = 1'b1; free_idx = IDX_W'(i); end
    end
  end

  lst_e rsp_st, fwd_st, core_st;
  assign rsp_st  = rsp_hit  ? st_q[rsp_idx]  : ST_I;
  assign fwd_st  = fwd_hit  ? st_q[fwd_idx]  : ST_I;
  assign core_st = core_hit ? st_q[core_idx] : ST_I;

  logic signed [ACK_W-1:0] r_ack, ack_sum, ack_dec;
  assign r_ack   = ack_q[rsp_idx];
  assign ack_sum = r_ack + rsp_acks;
  assign ack_dec = r_ack - {{(ACK_W-1){1'b0}}, 1'b1};

  logic fwd_stall, core_stall;
  assign fwd_stall = (fwd_st inside {ST_IS_D, ST_IM_AD, ST_IM_A, ST_SM_A}) ||
                     (fwd_st == ST_SM_AD && fwd_type != F_INV);

  always_comb begin
    case (core_st)
      ST_I:              core_stall = (core_op != OP_RP) && !have_free;
      ST_S, ST_M:        core_stall = 1'b0;
      ST_SM_AD, ST_SM_A: core_stall = (core_op != OP_LD);
      default:           core_stall = 1'b1;
    endcase
  end

  assign rsp_ready  = rsp_valid;
  assign fwd_ready  = fwd_valid && !fwd_stall && !rsp_ready;
  assign core_ready = core_valid && !core_stall && !rsp_ready && !fwd_ready;

  logic                    upd_en;
  logic [IDX_W-1:0]        upd_idx;
  lst_e                    upd_st;
  logic [ADDR_W-1:0]       upd_tag;
  logic signed [ACK_W-1:0] upd_ack;
  logic                    n_mv, n_hv, n_hs;
  logic [2:0]              n_mt;
  logic [ADDR_W-1:0]       n_ma, n_ha;
  logic [ID_W-1:0]         n_mi;

  always_comb begin
    upd_en = 1'b0; upd_idx = '0; upd_st = ST_I; upd_tag = '0; upd_ack = '0;
    n_mv = 1'b0; n_mt = '0; n_ma = '0; n_mi = '0;
    n_hv = 1'b0; n_hs = 1'b0; n_ha = '0;
    if (rsp_ready && rsp_hit) begin
      upd_en = 1'b1; upd_idx = rsp_idx; upd_st = rsp_st;
      upd_tag = rsp_addr; upd_ack = r_ack;
      n_ha = rsp_addr;
      case (rsp_st)
        ST_IS_D: if (rsp_type != R_IACK) begin upd_st = ST_S; n_hv = 1'b1; end
        ST_IM_AD, ST_SM_AD: begin
          if (rsp_type == R_OWN) begin
            upd_st = ST_M; upd_ack = '0; n_hv = 1'b1; n_hs = 1'b1;
          end else if (rsp_type == R_DIR) begin
            upd_ack = ack_sum;
            if (ack_sum == '0) begin upd_st = ST_M; n_hv = 1'b1; n_hs = 1'b1; end
            else upd_st = (rsp_st == ST_IM_AD) ? ST_IM_A : ST_SM_A;
          end else if (rsp_type == R_IACK) upd_ack = ack_dec;
        end
        ST_IM_A, ST_SM_A: if (rsp_type == R_IACK) begin
          upd_ack = ack_dec;
          if (ack_dec == '0) begin upd_st = ST_M; n_hv = 1'b1; n_hs = 1'b1; end
        end
        default: ;
      endcase
    end else if (fwd_ready && fwd_hit) begin
      upd_en = 1'b1; upd_idx = fwd_idx; upd_st = fwd_st;
      upd_tag = fwd_addr; upd_ack = ack_q[fwd_idx];
      n_ma = fwd_addr; n_mi = fwd_req_id;
      case (fwd_st)
        ST_S:     if (fwd_type == F_INV) begin upd_st = ST_I;     n_mv = 1'b1; n_mt = M_IACK; end
        ST_SM_AD: if (fwd_type == F_INV) begin upd_st = ST_IM_AD; n_mv = 1'b1; n_mt = M_IACK; end
        ST_SI_A: begin
          if (fwd_type == F_INV) begin upd_st = ST_II_A; n_mv = 1'b1; n_mt = M_IACK; end
          if (fwd_type == F_PACK) upd_st = ST_I;
        end
        ST_M, ST_MI_A: begin
          if (fwd_type == F_GETS) begin
            upd_st = (fwd_st == ST_M) ? ST_S : ST_SI_A; n_mv = 1'b1; n_mt = M_DBOTH;
          end
          if (fwd_type == F_GETM) begin
            upd_st = (fwd_st == ST_M) ? ST_I : ST_II_A; n_mv = 1'b1; n_mt = M_DREQ;
          end
          if (fwd_type == F_PACK && fwd_st == ST_MI_A) upd_st = ST_I;
        end
        ST_II_A: if (fwd_type == F_PACK) upd_st = ST_I;
        default: ;
      endcase
    end else if (core_ready) begin
      upd_idx = core_hit ? core_idx : free_idx;
      upd_st = core_st; upd_tag = core_addr; upd_ack = '0;
      n_ma = core_addr; n_ha = core_addr;
      case (core_st)
        ST_I: begin
          if (core_op == OP_LD) begin upd_en = 1'b1; upd_st = ST_IS_D;  n_mv = 1'b1; n_mt = M_GETS; end
          if (core_op == OP_ST) begin upd_en = 1'b1; upd_st = ST_IM_AD; n_mv = 1'b1; n_mt = M_GETM; end
        end
        ST_S: begin
          if (core_op == OP_LD) n_hv = 1'b1;
          if (core_op == OP_ST) begin upd_en = 1'b1; upd_st = ST_SM_AD; n_mv = 1'b1; n_mt = M_GETM; end
          if (core_op == OP_RP) begin upd_en = 1'b1; upd_st = ST_SI_A;  n_mv = 1'b1; n_mt = M_PUTS; end
        end
        ST_M: begin
          if (core_op == OP_LD) n_hv = 1'b1;
          if (core_op == OP_ST) begin n_hv = 1'b1; n_hs = 1'b1; end
          if (core_op == OP_RP) begin upd_en = 1'b1; upd_st = ST_MI_A; n_mv = 1'b1; n_mt = M_PUTM; end
        end
        default: if (core_op == OP_LD) n_hv = 1'b1;
      endcase
    end
    if (!n_mv) begin n_ma = '0; n_mi = '0; end
    if (!n_hv) n_ha = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i] <= ST_I; tag_q[i] <= '0; ack_q[i] <= '0;
      end
      msg_valid <= 1'b0; msg_type <= '0; msg_addr <= '0; msg_id <= '0;
      hit_valid <= 1'b0; hit_store <= 1'b0; hit_addr <= '0;
    end else begin
      if (upd_en) begin
        st_q[upd_idx]  <= upd_st;
        tag_q[upd_idx] <= upd_tag;
        ack_q[upd_idx] <= upd_ack;
      end
      msg_valid <= n_mv; msg_type <= n_mt; msg_addr <= n_ma; msg_id <= n_mi;
      hit_valid <= n_hv; hit_store <= n_hs; hit_addr <= n_ha;
    end
  end
endmodule

// File: rtl/msi_line_ctrl_chk.sv
module msi_line_ctrl_chk #(
  parameter int ID_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            core_valid,
  input logic            core_ready,
  input logic [1:0]      core_op,
  input logic            fwd_valid,
  input logic            fwd_ready,
  input logic [1:0]      fwd_type,
  input logic [ID_W-1:0] fwd_req_id,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic            msg_valid,
  input logic [2:0]      msg_type,
  input logic [ID_W-1:0] msg_id,
  input logic            hit_valid
);
  p_one_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_ready, fwd_ready, core_ready}));

  p_rsp_taken_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_ready);

  p_ready_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ready |-> core_valid) and (fwd_ready |-> fwd_valid));

  p_msg_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> $past(core_ready || fwd_ready));

  p_hit_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> $past(rsp_ready || core_ready));

  p_gets_from_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_type == 3'd0) |-> ($past(core_ready) && $past(core_op) == 2'd0));

  p_invack_from_inv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_type == 3'd4) |->
      ($past(fwd_ready) && $past(fwd_type) == 2'd0 && $past(fwd_req_id) == msg_id));
endmodule

bind msi_line_ctrl msi_line_ctrl_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .core_valid(core_valid), .core_ready(core_ready), .core_op(core_op),
  .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_type(fwd_type), .fwd_req_id(fwd_req_id),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .msg_valid(msg_valid), .msg_type(msg_type), .msg_id(msg_id),
  .hit_valid(hit_valid)
);

// File: tb/test_msi_line_ctrl.sv
module test_msi_line_ctrl;
  localparam int PERIOD = 10;
  localparam int AW = 16, IW = 4, KW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic core_valid = 0, fwd_valid = 0, rsp_valid = 0;
  logic core_ready, fwd_ready, rsp_ready;
  logic [1:0] core_op = 0, fwd_type = 0, rsp_type = 0;
  logic [AW-1:0] core_addr = 0, fwd_addr = 0, rsp_addr = 0;
  logic [IW-1:0] fwd_req_id = 0;
  logic signed [KW-1:0] rsp_acks = 0;
  logic msg_valid, hit_valid, hit_store;
  logic [2:0] msg_type;
  logic [AW-1:0] msg_addr, hit_addr;
  logic [IW-1:0] msg_id;

  msi_line_ctrl #(.LINES(4), .ADDR_W(AW), .ID_W(IW), .ACK_W(KW)) i_msi_line_ctrl (.*);

  always #(PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic g_cr, g_fr, g_rr, g_mv, g_hv, g_hs;
  logic [2:0] g_mt;
  logic [AW-1:0] g_ma, g_ha;
  logic [IW-1:0] g_mi;

  localparam logic [1:0] LD = 0, ST = 1, RP = 2;
  localparam logic [1:0] INV = 0, FGS = 1, FGM = 2, PACK = 3;
  localparam logic [1:0] DDIR = 0, DOWN = 1, IACK = 2;
  localparam logic [AW-1:0] A = 16'h0100, B = 16'h0200, C = 16'h0300,
                            D = 16'h0400, E = 16'h0500, F = 16'h0600;

  function automatic logic [31:0] mword(logic v, logic [2:0] t, logic [AW-1:0] a, logic [IW-1:0] id);
    return {v, t, id, 8'h00, a};
  endfunction
  function automatic logic [31:0] hword(logic v, logic s, logic [AW-1:0] a);
    return {v, s, 14'h0, a};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic cv, logic [1:0] cop, logic [AW-1:0] ca,
                       logic fv, logic [1:0] ft, logic [AW-1:0] fa, logic [IW-1:0] fid,
                       logic rv, logic [1:0] rt, logic [AW-1:0] ra, logic signed [KW-1:0] rk);
    core_valid = cv; core_op = cop; core_addr = ca;
    fwd_valid = fv; fwd_type = ft; fwd_addr = fa; fwd_req_id = fid;
    rsp_valid = rv; rsp_type = rt; rsp_addr = ra; rsp_acks = rk;
    #(PERIOD/4);
    g_cr = core_ready; g_fr = fwd_ready; g_rr = rsp_ready;
    @(posedge clk); #(PERIOD/4);
    core_valid = 0; fwd_valid = 0; rsp_valid = 0;
    g_mv = msg_valid; g_mt = msg_type; g_ma = msg_addr; g_mi = msg_id;
    g_hv = hit_valid; g_hs = hit_store; g_ha = hit_addr;
  endtask

  task automatic core(logic [1:0] op, logic [AW-1:0] a);
    drive(1, op, a, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic fwd(logic [1:0] t, logic [AW-1:0] a, logic [IW-1:0] id);
    drive(0, 0, 0, 1, t, a, id, 0, 0, 0, 0);
  endtask
  task automatic rsp(logic [1:0] t, logic [AW-1:0] a, logic signed [KW-1:0] k);
    drive(0, 0, 0, 0, 0, 0, 0, 1, t, a, k);
  endtask

  task automatic exp_msg(string r, logic [2:0] t, logic [AW-1:0] a, logic [IW-1:0] id);
    check(r, mword(g_mv, g_mt, g_ma, g_mi), mword(1, t, a, id));
  endtask
  task automatic no_msg(string r);
    check(r, mword(g_mv, g_mt, g_ma, g_mi), mword(0, 0, 0, 0));
  endtask
  task automatic exp_hit(string r, logic s, logic [AW-1:0] a);
    check(r, hword(g_hv, g_hs, g_ha), hword(1, s, a));
  endtask
  task automatic no_hit(string r);
    check(r, hword(g_hv, g_hs, g_ha), hword(0, 0, 0));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #(PERIOD/4) rst_n = 1'b1;
    @(posedge clk); #(PERIOD/4);
    check("R1", {30'd0, msg_valid, hit_valid}, 0);
    rsp(IACK, A, 0); check("R12", g_rr, 1); no_msg("R12"); no_hit("R1");

    core(LD, A); check("R2", g_cr, 1); exp_msg("R2", 3'd0, A, 0); no_hit("R1");
    core(LD, A); check("R2", g_cr, 0);
    core(ST, A); check("R2", g_cr, 0);
    core(RP, A); check("R2", g_cr, 0);
    fwd(INV, A, 1); check("R10", g_fr, 0); no_msg("R10");
    rsp(DDIR, A, 0); check("R3", g_rr, 1); exp_hit("R3", 0, A); no_msg("R3");

    core(LD, A); exp_hit("R6", 0, A);
    core(ST, A); exp_msg("R6", 3'd1, A, 0); no_hit("R6");
    core(LD, A); check("R6", g_cr, 1); exp_hit("R6", 0, A);
    core(ST, A); check("R6", g_cr, 0);
    fwd(FGS, A, 1); check("R10", g_fr, 0);
    fwd(INV, A, 3); check("R8", g_fr, 1); exp_msg("R8", 3'd4, A, 3);
    core(LD, A); check("R2", g_cr, 0);
    fwd(FGS, A, 1); check("R10", g_fr, 0);

    rsp(IACK, A, 0); no_hit("R5");
    rsp(DDIR, A, 2); no_hit("R5");
    fwd(FGM, A, 2); check("R10", g_fr, 0);
    rsp(IACK, A, 0); exp_hit("R5", 1, A);

    core(ST, A); exp_hit("R6", 1, A);
    core(LD, A); exp_hit("R6", 0, A);
    fwd(FGS, A, 5); exp_msg("R9", 3'd6, A, 5);
    core(LD, A); exp_hit("R9", 0, A);
    core(RP, A); exp_msg("R7", 3'd2, A, 0);
    core(LD, A); check("R7", g_cr, 0);
    fwd(INV, A, 2); exp_msg("R8", 3'd4, A, 2);
    core(ST, A); check("R7", g_cr, 0);
    fwd(PACK, A, 0); check("R7", g_fr, 1); no_msg("R7");
    core(LD, A); exp_msg("R7", 3'd0, A, 0);
    rsp(DOWN, A, 0); exp_hit("R3", 0, A);

    core(ST, B); exp_msg("R2", 3'd1, B, 0);
    rsp(DOWN, B, 3); exp_hit("R4", 1, B);
    fwd(FGM, B, 7); exp_msg("R9", 3'd5, B, 7);
    core(LD, B); exp_msg("R9", 3'd0, B, 0);
    rsp(DDIR, B, 0); exp_hit("R3", 0, B);

    core(LD, C); exp_msg("R12", 3'd0, C, 0);
    core(LD, D); exp_msg("R12", 3'd0, D, 0);
    core(LD, E); check("R12", g_cr, 0); no_msg("R12");
    core(RP, E); check("R12", g_cr, 1); no_msg("R12"); no_hit("R12");
    fwd(INV, E, 1); check("R12", g_fr, 1); no_msg("R12");

    drive(1, LD, A, 1, INV, A, 1, 1, IACK, E, 0);
    check("R11", {g_rr, g_fr, g_cr}, 3'b100); no_msg("R11"); no_hit("R11");
    drive(1, LD, A, 1, INV, C, 1, 0, 0, 0, 0);
    check("R11", {g_rr, g_fr, g_cr}, 3'b001); exp_hit("R11", 0, A);
    drive(1, LD, A, 1, INV, A, 6, 0, 0, 0, 0);
    check("R11", {g_rr, g_fr, g_cr}, 3'b010); exp_msg("R8", 3'd4, A, 6);
    rsp(DDIR, C, 0); exp_hit("R3", 0, C);
    rsp(DDIR, D, 0); exp_hit("R3", 0, D);

    core(ST, C); exp_msg("R6", 3'd1, C, 0);
    rsp(DDIR, C, 0); exp_hit("R4", 1, C);
    core(RP, C); exp_msg("R7", 3'd3, C, 0);
    core(LD, C); check("R7", g_cr, 0);
    fwd(FGS, C, 1); exp_msg("R9", 3'd6, C, 1);
    fwd(PACK, C, 0); no_msg("R7");
    core(LD, C); exp_msg("R7", 3'd0, C, 0);

    core(ST, D); exp_msg("R6", 3'd1, D, 0);
    rsp(DDIR, D, 1); no_hit("R5");
    core(LD, D); exp_hit("R6", 0, D);
    core(ST, D); check("R6", g_cr, 0);
    rsp(IACK, D, 0); exp_hit("R5", 1, D);
    core(RP, D); exp_msg("R7", 3'd3, D, 0);
    fwd(FGM, D, 4); exp_msg("R9", 3'd5, D, 4);
    core(LD, D); check("R7", g_cr, 0);
    fwd(PACK, D, 0); no_msg("R7");

    core(ST, E); exp_msg("R4", 3'd1, E, 0);
    rsp(DDIR, E, 0); exp_hit("R4", 1, E);

    for (int n = 0; n < 400; n++) begin
      logic cv, fv, rv;
      logic [1:0] cop, ft, rt;
      logic [AW-1:0] ca, fa, ra;
      cv = 1'($urandom); fv = 1'($urandom); rv = ($urandom % 4) == 0;
      cop = 2'($urandom % 3); ft = 2'($urandom); rt = 2'($urandom % 3);
      ca = 16'h0100 * (1 + $urandom % 6);
      fa = 16'h0100 * (1 + $urandom % 6);
      ra = 16'h0100 * (1 + $urandom % 6);
      drive(cv, cop, ca, fv, ft, fa, 4'($urandom), rv, rt, ra, 6'($urandom % 4));
      check("R11", {31'd0, $countones({g_rr, g_fr, g_cr}) <= 1}, 1);
      check("R11", {31'd0, g_rr}, {31'd0, rv});
      if (g_mv) check("R13", {15'd0, g_cr || g_fr, g_ma}, {15'd0, 1'b1, g_fr ? fa : ca});
      if (g_hv) check("R13", {15'd0, g_rr || g_cr, g_ha}, {15'd0, 1'b1, g_rr ? ra : ca});
    end
    summary();
  end
endmodule